// File: doc/BRIEF.md
# Wakeup Source Timer and Signaller

This block keeps a sleeping radio device able to wake itself and to tell its host why it woke. A slow RC oscillator tick drives a programmable divider and an application wakeup counter. Two other wake sources are accepted: a sniff energy-detect pulse from the receiver, and an external wake request, which the host makes by holding both serial-bus lines low.

The first source to fire is latched as the wake cause. The block then shows that cause to the host by pulling a chosen set of three shared pins low: the data pin, the bus data line and the bus clock line. Every pin output is an open-drain pull-down enable. The cause stays latched until the host clears it. The clear releases every pin and restarts the timer chain from zero. The serial-bus slave protocol is not part of this block.

Top module: `wake_signaller`

## Requirements
- R1: After reset, `wake_cause` is 0 (no wake) and `data_pd`, `sda_pd` and `scl_pd` are all 0.
- R2: With divider value D (`div_cfg`) and count value C (`cnt_cfg`), an application wake latches `wake_cause` = 1 on the (D+1)·(C+1)-th RC tick after reset or after a host clear. It does not latch earlier.
- R3: After an application wake, `data_pd` and `sda_pd` become 1 once P further divided periods have passed, where P is `delay_cfg` and one divided period is D+1 RC ticks. With P = 0 they become 1 together with the cause. `scl_pd` stays 0, and before the delay ends all three pins are 0. The pin vector {data,sda,scl} is 110.
- R4: A one-cycle `sniff_wake` pulse while no cause is latched sets `wake_cause` = 2 on the next clock. The pin vector is then 100: only the data pin is pulled low.
- R5: When `sda_in` and `scl_in` are both sampled low on two consecutive RC ticks, an external wake latches `wake_cause` = 3 with pin vector 101. A low seen on only a single tick, followed by a high, is ignored.
- R6: When several sources fire in the same clock cycle, external wins over sniff, and sniff wins over the application timer.
- R7: Once a cause is latched, further wake events leave `wake_cause` and the pins unchanged until a host clear.
- R8: A `host_clear` pulse releases all pins and returns `wake_cause` to 0 on the next clock. It restarts the divider, the wake counter and the glitch filter from zero, so R2 timing counts again from the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| div_cfg | input | 8 | Divider value D, divided period = D+1 RC ticks |
| cnt_cfg | input | 8 | Count value C, wake after C+1 divided periods |
| delay_cfg | input | 8 | Divided periods between an application wake and pin signalling |
| sniff_wake | input | 1 | Energy-detect wake pulse |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_in | input | 1 | Sensed level of the bus clock line |
| host_clear | input | 1 | Host clears the wake status |
| data_pd | output | 1 | Pull-down enable for the data pin |
| sda_pd | output | 1 | Pull-down enable for the bus data line |
| scl_pd | output | 1 | Pull-down enable for the bus clock line |
| wake_cause | output | 2 | 0 none, 1 application, 2 sniff, 3 external |

## Verification
A wrong divider or counter state shows up as a cause latched one or more RC ticks early or late. The bench compares the cause on every tick, so such an error is reported on the first tick where it differs. A broken glitch filter shows as an external wake after a single low tick. A wrong priority or latch shows as a changed `wake_cause` in the clock right after the competing event. A clear that fails to restart the chain misplaces the next wake by the residue left in the counters.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_APP   = 2'd1,
    CAUSE_SNIFF = 2'd2,
    CAUSE_EXT   = 2'd3
  } cause_t;

  // Pin vector {data, sda, scl}; the application pattern waits for its delay.
  function automatic logic [2:0] pin_pattern(cause_t c, logic app_go);
    case (c)
      CAUSE_APP:   return app_go ? 3'b110 : 3'b000;
      CAUSE_SNIFF: return 3'b100;
      CAUSE_EXT:   return 3'b101;
      default:     return 3'b000;
    endcase
  endfunction

  // Same-cycle priority: external, then sniff, then application timer.
  function automatic cause_t pick_cause(logic ext, logic sniff, logic app);
    if (ext)        return CAUSE_EXT;
    else if (sniff) return CAUSE_SNIFF;
    else if (app)   return CAUSE_APP;
    else            return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic         rc_tick,
  input  logic [W-1:0] div_cfg,
  input  logic [W-1:0] cnt_cfg,
  output logic         div_tick,
  output logic         app_fire
);
  logic [W-1:0] pre_cnt;
  logic [W-1:0] app_cnt;

  assign div_tick = rc_tick && (pre_cnt == div_cfg);
  assign app_fire = run && div_tick && (app_cnt == cnt_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      app_cnt <= '0;
    end else if (restart) begin
      pre_cnt <= '0;
      app_cnt <= '0;
    end else if (rc_tick) begin
      pre_cnt <= div_tick ? '0 : pre_cnt + 1'b1;
      if (div_tick && run)
        app_cnt <= (app_cnt == cnt_cfg) ? '0 : app_cnt + 1'b1;
    end
  end

  AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    app_fire |-> rc_tick && run) else $error("app fire off tick"); // R2
endmodule

// File: rtl/wake_ext_filter.sv
module wake_ext_filter #(
  parameter int FILT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic rc_tick,
  input  logic sda_in,
  input  logic scl_in,
  output logic ext_fire
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic          both_low;
  logic [CW-1:0] low_cnt;

  assign both_low = !sda_in && !scl_in;
  assign ext_fire = rc_tick && both_low && (low_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (restart)     low_cnt <= '0;
    else if (rc_tick) begin
      if (!both_low)            low_cnt <= '0;
      else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_EXT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fire |-> !sda_in && !scl_in) else $error("ext fire with line high"); // R5
endmodule

// File: rtl/wake_signaller.sv
module wake_signaller
  import wake_pkg::*;
#(
  parameter int W    = 8,
  parameter int FILT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rc_tick,
  input  logic [W-1:0] div_cfg,
  input  logic [W-1:0] cnt_cfg,
  input  logic [W-1:0] delay_cfg,
  input  logic         sniff_wake,
  input  logic         sda_in,
  input  logic         scl_in,
  input  logic         host_clear,
  output logic         data_pd,
  output logic         sda_pd,
  output logic         scl_pd,
  output logic [1:0]   wake_cause
);
  cause_t       cause_q;
  cause_t       winner;
  logic         asleep;
  logic         div_tick;
  logic         app_fire;
  logic         ext_fire;
  logic         app_go;
  logic [W-1:0] dly_cnt;
  logic [2:0]   pins;

  assign asleep = (cause_q == CAUSE_NONE);

  wake_prescaler #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(host_clear), .run(asleep),
    .rc_tick(rc_tick), .div_cfg(div_cfg), .cnt_cfg(cnt_cfg),
    .div_tick(div_tick), .app_fire(app_fire)
  );

  wake_ext_filter #(.FILT(FILT)) u_ext (
    .clk(clk), .rst_n(rst_n), .restart(host_clear), .rc_tick(rc_tick),
    .sda_in(sda_in), .scl_in(scl_in), .ext_fire(ext_fire)
  );

  assign winner = pick_cause(ext_fire, sniff_wake, app_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      app_go  <= 1'b0;
      dly_cnt <= '0;
    end else if (host_clear) begin
      cause_q <= CAUSE_NONE;
      app_go  <= 1'b0;
      dly_cnt <= '0;
    end else if (asleep) begin
      cause_q <= winner;
      app_go  <= (winner == CAUSE_APP) && (delay_cfg == '0);
      dly_cnt <= '0;
    end else if (cause_q == CAUSE_APP && !app_go && div_tick) begin
      if (dly_cnt == delay_cfg - 1'b1) app_go <= 1'b1;
      else                             dly_cnt <= dly_cnt + 1'b1;
    end
  end

  assign pins       = pin_pattern(cause_q, app_go);
  assign data_pd    = pins[2];
  assign sda_pd     = pins[1];
  assign scl_pd     = pins[0];
  assign wake_cause = cause_q;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == CAUSE_NONE) |-> !data_pd && !sda_pd && !scl_pd) else $error("pins while asleep"); // R1
  AST_APP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pd |-> data_pd && !scl_pd && cause_q == CAUSE_APP) else $error("bad app pins"); // R3
  AST_SNIFF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && sniff_wake && !ext_fire && !host_clear) |=> cause_q == CAUSE_SNIFF) else $error("sniff lost"); // R4
  AST_SCL_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pd |-> cause_q == CAUSE_EXT && data_pd) else $error("scl pulled w/o ext"); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && ext_fire && !host_clear) |=> cause_q == CAUSE_EXT) else $error("ext not preferred"); // R6
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !host_clear) |=> cause_q == $past(cause_q)) else $error("cause changed"); // R7
  AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> cause_q == CAUSE_NONE && !data_pd && !sda_pd && !scl_pd) else $error("clear ignored"); // R8
endmodule

// File: tb/wake_signaller_test.sv
module wake_signaller_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rc_tick = 0;
  logic [7:0] div_cfg = 8'd255;
  logic [7:0] cnt_cfg = 8'd255;
  logic [7:0] delay_cfg = 8'd0;
  logic       sniff_wake = 0;
  logic       sda_in = 1;
  logic       scl_in = 1;
  logic       host_clear = 0;
  logic       data_pd, sda_pd, scl_pd;
  logic [1:0] wake_cause;

  int checks = 0;
  int errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  wake_signaller uut (
    .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .div_cfg(div_cfg),
    .cnt_cfg(cnt_cfg), .delay_cfg(delay_cfg), .sniff_wake(sniff_wake),
    .sda_in(sda_in), .scl_in(scl_in), .host_clear(host_clear),
    .data_pd(data_pd), .sda_pd(sda_pd), .scl_pd(scl_pd), .wake_cause(wake_cause)
  );

  function automatic int wake_tick(int d, int c);
    return (d + 1) * (c + 1);
  endfunction

  function automatic int signal_tick(int d, int c, int p);
    return wake_tick(d, c) + p * (d + 1);
  endfunction

  // Expected {cause, data, sda, scl}
  function automatic logic [4:0] expect_vec(int cause, logic app_pins_on);
    case (cause)
      1: return {2'd1, app_pins_on ? 3'b110 : 3'b000};
      2: return {2'd2, 3'b100};
      3: return {2'd3, 3'b101};
      default: return 5'b0;
    endcase
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {wake_cause, data_pd, sda_pd, scl_pd};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual cause/pins %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) rc_tick = 1;
    @(negedge clk) rc_tick = 0;
  endtask

  task automatic clear();
    @(negedge clk) host_clear = 1;
    @(negedge clk) host_clear = 0;
  endtask

  task automatic sniff();
    @(negedge clk) sniff_wake = 1;
    @(negedge clk) sniff_wake = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", 5'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset release", 5'b0);

    // R2/R3 directed corners then random configs
    for (int trial = 0; trial < 20; trial++) begin
      int d, c, p, w, s;
      if (trial == 0)      begin d = 0; c = 0; p = 0; end
      else if (trial == 1) begin d = 0; c = 0; p = 2; end
      else if (trial == 2) begin d = 3; c = 0; p = 1; end
      else begin
        d = $urandom_range(0, 7); c = $urandom_range(0, 7); p = $urandom_range(0, 3);
      end
      div_cfg = 8'(d); cnt_cfg = 8'(c); delay_cfg = 8'(p);
      clear();
      check("R8 clear releases", 5'b0);
      w = wake_tick(d, c);
      s = signal_tick(d, c, p);
      for (int t = 1; t <= s + 1; t++) begin
        tick();
        check(t < w ? "R2 app wake timing" : "R3 app signal delay",
              expect_vec(t >= w ? 1 : 0, t >= s));
      end
    end

    // Keep the timer far away for the remaining tests
    div_cfg = 8'd255; cnt_cfg = 8'd255; delay_cfg = 8'd0;
    clear();

    // R4 sniff
    sniff();
    check("R4 sniff wake", expect_vec(2, 0));
    // R7 latched: external request ignored
    sda_in = 0; scl_in = 0;
    repeat (3) tick();
    check("R7 cause held after ext request", expect_vec(2, 0));
    sda_in = 1; scl_in = 1;
    clear();
    check("R8 clear after sniff", 5'b0);

    // R5 external with glitch filter
    sda_in = 0; scl_in = 0; tick();
    check("R5 single low tick ignored", 5'b0);
    sda_in = 1; scl_in = 1; tick();
    sda_in = 0; scl_in = 0; tick();
    check("R5 glitch does not accumulate", 5'b0);
    tick();
    check("R5 external wake", expect_vec(3, 0));
    sda_in = 1; scl_in = 1;
    sniff();
    check("R7 sniff ignored after ext", expect_vec(3, 0));
    clear();
    check("R8 clear after ext", 5'b0);

    // R6 ext beats sniff in same cycle
    sda_in = 0; scl_in = 0; tick();
    @(negedge clk) begin rc_tick = 1; sniff_wake = 1; end
    @(negedge clk) begin rc_tick = 0; sniff_wake = 0; end
    check("R6 ext over sniff", expect_vec(3, 0));
    sda_in = 1; scl_in = 1;
    clear();

    // R6 sniff beats app timer (fires on first tick with d=c=0)
    div_cfg = 8'd0; cnt_cfg = 8'd0; delay_cfg = 8'd0;
    clear();
    @(negedge clk) begin rc_tick = 1; sniff_wake = 1; end
    @(negedge clk) begin rc_tick = 0; sniff_wake = 0; end
    check("R6 sniff over app", expect_vec(2, 0));
    clear();

    // R8 restart from zero: partial progress discarded
    div_cfg = 8'd1; cnt_cfg = 8'd2;
    clear();
    repeat (4) tick();
    clear();
    for (int t = 1; t <= 6; t++) begin
      tick();
      check("R8 timer restarts after clear", expect_vec(t >= 6 ? 1 : 0, t >= 6));
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule